// File: doc/BRIEF.md
# Freezable Event Counter Bank

This block is a bank of hardware event counters for performance measurement. One wide counter advances on every clock and measures elapsed time. A set of narrower counters each watch one line of an event vector. The line is picked per counter by a small select field. Whenever the picked line is high in a cycle, that counter adds one.

Software controls the bank through a plain register port: one write port and one combinational read port that share a single address map. Each event counter has its own stop bit. A separate stop-all bit halts the whole bank, including the time counter. While stopped, software may load counter values and change select fields without disturbing any stop bit. Clearing the stop condition is what restarts counting, so a measurement run is set up as follows: stop, load, select, release.

The address is split into a slot (upper bits) and a register within the slot (two low bits). Slot 0 holds the global controls and the time counter. Slot n, for n from 1 upward, belongs to event counter n. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `evtctr_bank`

## Requirements
- R1: Synchronous active-high reset. It clears the time counter, every event counter, every select field and every per-counter stop bit. It sets the stop-all bit.
- R2: The time counter is CYC_W (64) bits wide. It adds one on every clock edge at which the stop-all bit is clear, and it ignores the per-counter stop bits. Its low 32 bits read and write at address 2 and its high 32 bits at address 3; a half write leaves the other half as it was.
- R3: Event counter n is EVT_W (32) bits wide. It adds one at a clock edge where ev[select_n] is high, it is not stopped, and it is not being written. Its value reads and writes at address 4*n+1.
- R4: Address 1 holds the per-counter stop bits: bit n stops only event counter n. Bit 0 reads as zero.
- R5: Bit 0 of address 0 is the stop-all bit. While it is set, no counter changes except by a software write.
- R6: A counter counts at the first clock edge after the edge that wrote its stop condition clear.
- R7: Select fields (address 4*n, bits 5:0) and counter values can be written while stopped. Such writes leave both stop registers unchanged.
- R8: A software write to a counter takes priority over an increment in the same cycle; the written value is what is stored.
- R9: Counters wrap to zero past their maximum. The time counter carries from its low half into its high half.
- R10: Addresses that are not mapped (registers 2 and 3 of slots 1 and up, and slots above the last counter) read as zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev | input | NUM_SRC (64) | Event lines, one pulse per qualified event per cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address (slot, register) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address (slot, register) |
| rd_data | output | 32 | Combinational read data for rd_addr |

## Verification
The bench builds the bank with its default parameters: nine event counters, a 64-line event vector, a 64-bit time counter and a 6-bit address. With those values the top select code 63 reaches a real line, a 32-bit counter can be driven across its wrap in two cycles, and the time counter's carry between halves is reached by loading its low word. The 6-bit address also leaves slots 10 to 15 and the unused registers of each counter slot available as unmapped targets. A behavioural model runs beside the design while the read address sweeps the whole map every clock.

// File: rtl/evtctr_pkg.sv
package evtctr_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 6;
  localparam int SLOT_W = ADDR_W - 2;

  // registers within slot 0
  localparam logic [1:0] G_FRZ_ALL  = 2'd0;
  localparam logic [1:0] G_FRZ_MASK = 2'd1;
  localparam logic [1:0] G_CYC_LO   = 2'd2;
  localparam logic [1:0] G_CYC_HI   = 2'd3;

  // registers within an event counter slot
  localparam logic [1:0] C_SEL = 2'd0;
  localparam logic [1:0] C_VAL = 2'd1;

  function automatic logic [ADDR_W-1:0] reg_addr(input int slot, input logic [1:0] rg);
    return {SLOT_W'(slot), rg};
  endfunction
endpackage

// File: rtl/evtctr_dec.sv
module evtctr_dec
  import evtctr_pkg::*;
#(
  parameter int NUM_CTR = 9
) (
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  output logic               wr_fa,
  output logic               wr_mask,
  output logic               wr_cyc_lo,
  output logic               wr_cyc_hi,
  output logic [NUM_CTR:1]   wr_sel,
  output logic [NUM_CTR:1]   wr_val
);
  logic [SLOT_W-1:0] slot;
  logic [1:0]        rg;
  logic              glb;

  assign slot = wr_addr[ADDR_W-1:2];
  assign rg   = wr_addr[1:0];
  assign glb  = wr_en && (slot == '0);

  assign wr_fa     = glb && (rg == G_FRZ_ALL);
  assign wr_mask   = glb && (rg == G_FRZ_MASK);
  assign wr_cyc_lo = glb && (rg == G_CYC_LO);
  assign wr_cyc_hi = glb && (rg == G_CYC_HI);

  for (genvar n = 1; n <= NUM_CTR; n++) begin : g_slot
    logic hit;
    assign hit       = wr_en && (slot == SLOT_W'(n));
    assign wr_sel[n] = hit && (rg == C_SEL);
    assign wr_val[n] = hit && (rg == C_VAL);
  end
endmodule

// File: rtl/evtctr_regs.sv
module evtctr_regs #(
  parameter int NUM_CTR = 9,
  parameter int SEL_W   = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_fa,
  input  logic                          wr_mask,
  input  logic [NUM_CTR:1]              wr_sel,
  input  logic [NUM_CTR:0]              cfg_d,
  input  logic [SEL_W-1:0]              sel_d,
  output logic                          freeze_all,
  output logic [NUM_CTR:1]              frz_mask,
  output logic [NUM_CTR:1][SEL_W-1:0]   sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_all <= 1'b1;
      frz_mask   <= '0;
    end else begin
      if (wr_fa)   freeze_all <= cfg_d[0];
      if (wr_mask) frz_mask   <= cfg_d[NUM_CTR:1];
    end
  end

  for (genvar n = 1; n <= NUM_CTR; n++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)            sel_q[n] <= '0;
      else if (wr_sel[n]) sel_q[n] <= sel_d;
    end
  end
endmodule

// File: rtl/evtctr_evsel.sv
module evtctr_evsel #(
  parameter int NUM_SRC = 64,
  parameter int SEL_W   = 6
) (
  input  logic [NUM_SRC-1:0] ev,
  input  logic [SEL_W-1:0]   sel,
  output logic               hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) hit = ev[i];
    end
  end
endmodule

// File: rtl/evtctr_counter.sv
module evtctr_counter
  import evtctr_pkg::*;
#(
  parameter int W = 32   // at most 2*REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [REG_W-1:0] wdata,
  output logic [W-1:0]     value
);
  logic [W-1:0] nxt;

  if (W > REG_W) begin : g_wide
    always_comb begin
      nxt = value;
      if (wr_lo) nxt[REG_W-1:0] = wdata;
      if (wr_hi) nxt[W-1:REG_W] = wdata[W-REG_W-1:0];
      if (!wr_lo && !wr_hi && run && inc) nxt = value + W'(1);
    end
  end else begin : g_narrow
    always_comb begin
      nxt = value;
      if (wr_lo)                    nxt = wdata[W-1:0];
      else if (!wr_hi && run && inc) nxt = value + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= nxt;
  end
endmodule

// File: rtl/evtctr_bank.sv
module evtctr_bank
  import evtctr_pkg::*;
#(
  parameter int NUM_CTR = 9,
  parameter int EVT_W   = 32,
  parameter int CYC_W   = 64,
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] ev,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data
);
  localparam int SEL_W = $clog2(NUM_SRC);

  logic                        wr_fa, wr_mask, wr_cyc_lo, wr_cyc_hi;
  logic [NUM_CTR:1]            wr_sel, wr_val;
  logic                        freeze_all;
  logic [NUM_CTR:1]            frz_mask;
  logic [NUM_CTR:1][SEL_W-1:0] sel_q;
  logic [CYC_W-1:0]            cyc_q;
  logic [NUM_CTR:1][EVT_W-1:0] cnt_q;

  evtctr_dec #(.NUM_CTR(NUM_CTR)) u_dec (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_fa     (wr_fa),
    .wr_mask   (wr_mask),
    .wr_cyc_lo (wr_cyc_lo),
    .wr_cyc_hi (wr_cyc_hi),
    .wr_sel    (wr_sel),
    .wr_val    (wr_val)
  );

  evtctr_regs #(.NUM_CTR(NUM_CTR), .SEL_W(SEL_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_fa      (wr_fa),
    .wr_mask    (wr_mask),
    .wr_sel     (wr_sel),
    .cfg_d      (wr_data[NUM_CTR:0]),
    .sel_d      (wr_data[SEL_W-1:0]),
    .freeze_all (freeze_all),
    .frz_mask   (frz_mask),
    .sel_q      (sel_q)
  );

  // time counter: obeys only the stop-all bit
  evtctr_counter #(.W(CYC_W)) u_cyc (
    .clk   (clk),
    .rst   (rst),
    .run   (!freeze_all),
    .inc   (1'b1),
    .wr_lo (wr_cyc_lo),
    .wr_hi (wr_cyc_hi),
    .wdata (wr_data),
    .value (cyc_q)
  );

  for (genvar n = 1; n <= NUM_CTR; n++) begin : g_ctr
    logic hit;

    evtctr_evsel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
      .ev  (ev),
      .sel (sel_q[n]),
      .hit (hit)
    );

    evtctr_counter #(.W(EVT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .run   (!(freeze_all || frz_mask[n])),
      .inc   (hit),
      .wr_lo (wr_val[n]),
      .wr_hi (1'b0),
      .wdata (wr_data),
      .value (cnt_q[n])
    );
  end

  // read mux
  logic [SLOT_W-1:0] rd_slot;
  logic [1:0]        rd_rg;
  assign rd_slot = rd_addr[ADDR_W-1:2];
  assign rd_rg   = rd_addr[1:0];

  always_comb begin
    rd_data = '0;
    if (rd_slot == '0) begin
      case (rd_rg)
        G_FRZ_ALL:  rd_data = REG_W'(freeze_all);
        G_FRZ_MASK: rd_data = REG_W'({frz_mask, 1'b0});
        G_CYC_LO:   rd_data = cyc_q[REG_W-1:0];
        default:    rd_data = REG_W'(cyc_q >> REG_W);
      endcase
    end else begin
      for (int n = 1; n <= NUM_CTR; n++) begin
        if (rd_slot == SLOT_W'(n)) begin
          if (rd_rg == C_SEL)      rd_data = REG_W'(sel_q[n]);
          else if (rd_rg == C_VAL) rd_data = REG_W'(cnt_q[n]);
        end
      end
    end
  end
endmodule

// File: rtl/evtctr_bank_chk.sv
module evtctr_bank_chk
  import evtctr_pkg::*;
#(
  parameter int NUM_CTR = 9,
  parameter int EVT_W   = 32,
  parameter int CYC_W   = 64,
  parameter int NUM_SRC = 64,
  parameter int SEL_W   = 6
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_SRC-1:0]          ev,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic [REG_W-1:0]            wr_data,
  input logic                        wr_cyc_lo,
  input logic                        wr_cyc_hi,
  input logic [NUM_CTR:1]            wr_val,
  input logic                        freeze_all,
  input logic [NUM_CTR:1]            frz_mask,
  input logic [NUM_CTR:1][SEL_W-1:0] sel_q,
  input logic [CYC_W-1:0]            cyc_q,
  input logic [NUM_CTR:1][EVT_W-1:0] cnt_q
);
  logic [NUM_CTR:1] hit_c;
  always_comb begin
    for (int n = 1; n <= NUM_CTR; n++) hit_c[n] = ev[sel_q[n]];
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (freeze_all && cyc_q == '0 && frz_mask == '0));

  p_cyc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!freeze_all && !wr_cyc_lo && !wr_cyc_hi) |=> (cyc_q == $past(cyc_q) + CYC_W'(1)));

  p_cyc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (freeze_all && !wr_cyc_lo && !wr_cyc_hi) |=> $stable(cyc_q));

  p_frz_kept_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == reg_addr(0, G_FRZ_ALL)) |=> $stable(freeze_all));

  p_mask_kept_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == reg_addr(0, G_FRZ_MASK)) |=> $stable(frz_mask));

  for (genvar n = 1; n <= NUM_CTR; n++) begin : g_chk
    p_evt_step_r3: assert property (@(posedge clk) disable iff (rst)
      (!freeze_all && !frz_mask[n] && !wr_val[n])
      |=> (cnt_q[n] == $past(cnt_q[n]) + EVT_W'($past(hit_c[n]))));

    p_own_freeze_r4: assert property (@(posedge clk) disable iff (rst)
      (frz_mask[n] && !wr_val[n]) |=> $stable(cnt_q[n]));

    p_all_freeze_r5: assert property (@(posedge clk) disable iff (rst)
      (freeze_all && !wr_val[n]) |=> $stable(cnt_q[n]));

    p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
      wr_val[n] |=> (cnt_q[n] == $past(wr_data[EVT_W-1:0])));
  end
endmodule

bind evtctr_bank evtctr_bank_chk #(
  .NUM_CTR (NUM_CTR),
  .EVT_W   (EVT_W),
  .CYC_W   (CYC_W),
  .NUM_SRC (NUM_SRC),
  .SEL_W   (SEL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ev         (ev),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_cyc_lo  (wr_cyc_lo),
  .wr_cyc_hi  (wr_cyc_hi),
  .wr_val     (wr_val),
  .freeze_all (freeze_all),
  .frz_mask   (frz_mask),
  .sel_q      (sel_q),
  .cyc_q      (cyc_q),
  .cnt_q      (cnt_q)
);

// File: tb/evtctr_bank_test.sv
`timescale 1ns/1ps
module evtctr_bank_test;
  localparam int NC = 9;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] ev = '0;
  logic          wr_en = 1'b0;
  logic [5:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [5:0]    rd_addr = '0;
  logic [31:0]   rd_data;

  always #2 clk = ~clk;   // 250 MHz

  evtctr_bank uut (
    .clk(clk), .rst(rst), .ev(ev), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // behavioural reference model
  logic [63:0] m_cyc;
  logic [31:0] m_cnt [1:NC];
  logic [5:0]  m_sel [1:NC];
  logic        m_fa;
  logic [NC:1] m_mask;

  always @(posedge clk) begin
    if (rst) begin
      m_cyc <= '0; m_fa <= 1'b1; m_mask <= '0;
      for (int n = 1; n <= NC; n++) begin m_cnt[n] <= '0; m_sel[n] <= '0; end
    end else begin
      if (wr_en && wr_addr == 6'd2)      m_cyc <= {m_cyc[63:32], wr_data};
      else if (wr_en && wr_addr == 6'd3) m_cyc <= {wr_data, m_cyc[31:0]};
      else if (!m_fa)                    m_cyc <= m_cyc + 64'd1;
      if (wr_en && wr_addr == 6'd0) m_fa   <= wr_data[0];
      if (wr_en && wr_addr == 6'd1) m_mask <= wr_data[NC:1];
      for (int n = 1; n <= NC; n++) begin
        if (wr_en && wr_addr == 6'(4*n)) m_sel[n] <= wr_data[5:0];
        if (wr_en && wr_addr == 6'(4*n+1)) m_cnt[n] <= wr_data;
        else if (!m_fa && !m_mask[n] && ev[m_sel[n]]) m_cnt[n] <= m_cnt[n] + 32'd1;
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [5:0] a);
    int s = int'(a[5:2]);
    if (s == 0) begin
      case (a[1:0])
        2'd0: return {31'd0, m_fa};
        2'd1: return 32'({m_mask, 1'b0});
        2'd2: return m_cyc[31:0];
        default: return m_cyc[63:32];
      endcase
    end
    if (s <= NC && a[1:0] == 2'd0) return {26'd0, m_sel[s]};
    if (s <= NC && a[1:0] == 2'd1) return m_cnt[s];
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    int s = int'(a[5:2]);
    if (s == 0) begin
      if (a[1:0] == 2'd0) return "R5";
      if (a[1:0] == 2'd1) return "R4";
      return "R2";
    end
    if (s <= NC && a[1:0] == 2'd0) return "R7";
    if (s <= NC && a[1:0] == 2'd1) return "R3";
    return "R10";
  endfunction

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input logic [5:0] a);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, act, exp);
    end
  endtask

  // one clock; then compare the swept read address against the model
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    #0.1;
    chk(tag_of(rd_addr), rd_data, model_rd(rd_addr), rd_addr);
    rd_addr = rd_addr + 6'd1;
  endtask

  task automatic peek(input logic [5:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    #0.2;
    chk(tag, rd_data, exp, a);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    peek(6'd0, 32'd1, "R1");
    peek(6'd1, 32'd0, "R1");
    peek(6'd2, 32'd0, "R1");
    peek(6'd5, 32'd0, "R1");
    peek(6'd4, 32'd0, "R1");

    // R7: configure while frozen
    wr(6'd4, 32'd5);
    wr(6'd8, 32'd5);
    wr(6'd12, 32'd63);
    wr(6'd1, 32'h4);          // stop counter 2 only
    peek(6'd0, 32'd1, "R7");
    peek(6'd1, 32'd4, "R7");
    peek(6'd12, 32'd63, "R7");

    // R6: counting starts at the edge right after release
    wr(6'd0, 32'd0);
    ev[5] = 1'b1;
    repeat (4) cyc();
    ev[5] = 1'b0;
    peek(6'd5, 32'd4, "R6");
    peek(6'd9, 32'd0, "R4");
    peek(6'd2, 32'd4, "R2");

    // R8: write beats increment
    ev[5] = 1'b1;
    wr(6'd5, 32'd100);
    ev[5] = 1'b0;
    peek(6'd5, 32'd100, "R8");

    // R9: wrap of an event counter and carry in the time counter
    wr(6'd13, 32'hFFFF_FFFF);
    ev[63] = 1'b1;
    cyc();
    ev[63] = 1'b0;
    peek(6'd13, 32'd0, "R9");
    wr(6'd2, 32'hFFFF_FFFF);
    cyc();
    peek(6'd3, 32'd1, "R9");
    peek(6'd2, 32'd0, "R9");

    // R10: unmapped addresses
    wr(6'd6, 32'hDEAD_BEEF);
    wr(6'd60, 32'h1234_5678);
    peek(6'd6, 32'd0, "R10");
    peek(6'd60, 32'd0, "R10");
    peek(6'd4, 32'd5, "R10");
    peek(6'd5, 32'd100, "R10");

    // R5 and R7: stop-all, then rewrite while stopped
    wr(6'd0, 32'd1);
    ev = '1;
    wr(6'd9, 32'd7);
    wr(6'd8, 32'd2);
    repeat (3) cyc();
    ev = '0;
    peek(6'd0, 32'd1, "R7");
    peek(6'd1, 32'd4, "R7");
    peek(6'd9, 32'd7, "R7");
    peek(6'd5, 32'd100, "R5");
    peek(6'd13, 32'd0, "R5");

    // mixed traffic against the model
    wr(6'd1, 32'd0);
    wr(6'd0, 32'd0);
    for (int i = 0; i < 600; i++) begin
      ev = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1;
        wr_addr = 6'($urandom_range(0, 47));
        wr_data = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFE : $urandom();
        if (wr_addr == 6'd0) wr_data = {31'd0, ($urandom_range(0, 2) == 0)};
      end
      cyc();
      wr_en = 1'b0;
    end
    finish_run();
  end
endmodule